// File: doc/BRIEF.md
# Masked-Address Data Watchpoint Comparator

This block watches a stream of memory and I/O accesses for addresses of interest. It holds four watch slots. Each slot has a base address, a window size of 1, 2, 4 or 8 bytes, an access-kind filter and an enable bit. Every access presented on the request side is compared against all four slots at once. The block reports which slots matched and raises a single combined break pulse. Both results are registered, so they appear one cycle after the request.

The comparison is deliberately not a range test. The window size selects a set of low address bits that are cleared on both the slot address and the access address before they are compared with an XOR. A slot whose base is not aligned to its window size therefore watches the aligned window that contains that base. A 4-byte slot at 0xF02 watches 0xF00 to 0xF03 and misses 0xF04. For I/O accesses, only the low 16 bits of the request address form the port number. That port number is zero-extended before the compare.

Slots are loaded through a one-slot-per-cycle configuration port. A write is seen by requests from the following cycle onward.

Top module: `wpt_unit`

## Requirements
- R1: After reset, `hit_vec` and `brk_pulse` are 0 and every slot is disabled, so a valid request hits nothing until a slot is written.
- R2: Results are registered. `hit_vec` and `brk_pulse` reflect the request from the previous cycle. A cycle with `req_valid` low yields all-zero results on the next cycle.
- R3: Size code 2'b00 (1 byte) compares every address bit. Only the exact address hits.
- R4: Size code 2'b01 (2 bytes) ignores bit 0 on both sides. A slot at 0x2001 hits 0x2000 and 0x2001 but not 0x2002.
- R5: Size code 2'b11 (4 bytes) ignores bits 1:0 on both sides, and an unaligned base is not corrected. A slot at 0xF02 hits 0xF00 and 0xF03 but not 0xF04.
- R6: Size code 2'b10 (8 bytes) ignores bits 2:0 on both sides. A slot at 0x3008 hits 0x300F but not 0x3007 or 0x3010.
- R7: A slot with its enable at 0, or with kind code 2'b00, never hits.
- R8: Kind code 2'b01 hits only memory writes (`req_is_write`=1, `req_is_io`=0).
- R9: Kind code 2'b10 hits only I/O accesses, reads or writes. For these, the compared address is `{16'h0, req_addr[15:0]}`, so `req_addr[31:16]` is ignored.
- R10: Kind code 2'b11 hits memory reads and writes but never I/O accesses.
- R11: Slots are independent. Several bits of `hit_vec` may be set in one cycle, where bit n belongs to slot n, and `brk_pulse` is the OR of `hit_vec`.
- R12: A configuration write takes effect for requests in the next cycle. A request in the same cycle as the write is compared against the slot's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | 32 | Access address (low 16 bits are the port number for I/O) |
| req_is_write | input | 1 | 1 = write, 0 = read |
| req_is_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_wr_en | input | 1 | Load one slot this cycle |
| cfg_slot | input | 2 | Index of the slot to load |
| cfg_addr | input | 32 | Slot base address |
| cfg_len | input | 2 | Window size code: 00=1, 01=2, 11=4, 10=8 bytes |
| cfg_kind | input | 2 | Kind filter: 00 none, 01 memory write, 10 I/O, 11 memory read/write |
| cfg_enable | input | 1 | Slot enable |
| hit_vec | output | 4 | Per-slot match for the previous cycle's request |
| brk_pulse | output | 1 | Any slot matched the previous cycle's request |

## Verification
The assertions assume that reset is applied from the first clock edge and that `cfg_slot` always names an existing slot. They also assume that every input is held stable around the rising edge. The bench drives all inputs on the falling edge and keeps every slot index in range. It holds reset low across the first edges, so the per-slot properties about disabled slots and the write-only filter only see configuration writes made after reset. These properties compare a configuration write against the result two cycles later. That comparison holds because a second write in the following cycle cannot affect the compare already under way.

// File: rtl/wpt_pkg.sv
// Package wpt_pkg
// Shared encodings for the watchpoint comparator: window size codes,
// access-kind filter codes and the per-slot control record.
// Assumes the size code bit pattern is fixed by software and is not
// ordered by size (4 bytes is 2'b11, 8 bytes is 2'b10).
package wpt_pkg;

    typedef enum logic [1:0] {
        WIN_1B = 2'b00,
        WIN_2B = 2'b01,
        WIN_8B = 2'b10,
        WIN_4B = 2'b11
    } win_e;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'b00,
        KIND_MWR   = 2'b01,
        KIND_IO    = 2'b10,
        KIND_MRW   = 2'b11
    } kind_e;

    typedef struct packed {
        logic  en;
        win_e  win;
        kind_e kind;
    } slot_ctl_t;

    localparam int LOW_BITS = 3;

    // Low address bits that a given window size leaves out of the compare.
    function automatic logic [LOW_BITS-1:0] win_drop_bits(win_e w);
        logic [LOW_BITS-1:0] d;
        case (w)
            WIN_1B:  d = 3'b000;
            WIN_2B:  d = 3'b001;
            WIN_4B:  d = 3'b011;
            default: d = 3'b111;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/wpt_slot_bank.sv
// Module wpt_slot_bank
// Storage for all watch slots. One slot may be loaded per cycle. The new
// contents become visible on the output in the cycle after the write.
// Assumes wr_idx is below NUM_SLOTS whenever wr_en is high. Writes with an
// out-of-range index are dropped.
module wpt_slot_bank
    import wpt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  slot_ctl_t                         wr_ctl,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_addr,
    output slot_ctl_t [NUM_SLOTS-1:0]         slot_ctl
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic sel;

        // Decode whether this slot is the write target.
        always_comb begin
            sel = wr_en && (wr_idx == IDX_W'(s));
        end

        // Hold one slot, cleared to disabled on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_addr[s] <= '0;
                slot_ctl[s]  <= '{en: 1'b0, win: WIN_1B, kind: KIND_NONE};
            end else if (sel) begin
                slot_addr[s] <= wr_addr;
                slot_ctl[s]  <= wr_ctl;
            end
        end
    end

endmodule

// File: rtl/wpt_access_norm.sv
// Module wpt_access_norm
// Forms the address used for comparison. Memory accesses pass through
// unchanged. I/O accesses keep only the port number and zero-extend it.
// Assumes ADDR_W >= IO_W.
module wpt_access_norm #(
    parameter int ADDR_W = 32,
    parameter int IO_W   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic [ADDR_W-1:0] cmp_addr
);

    // Select the memory or the zero-extended port address.
    always_comb begin
        if (is_io) begin
            cmp_addr = {{(ADDR_W-IO_W){1'b0}}, addr[IO_W-1:0]};
        end else begin
            cmp_addr = addr;
        end
    end

endmodule

// File: rtl/wpt_slot_cmp.sv
// Module wpt_slot_cmp
// Matches one access against one slot. The address compare is an XOR under
// a mask set by the window size, not a range test. The kind filter and the
// enable then qualify the result.
// Assumes ADDR_W is at least the number of maskable low bits.
module wpt_slot_cmp
    import wpt_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_io,
    input  logic [ADDR_W-1:0] slot_addr,
    input  slot_ctl_t         slot_ctl,
    output logic              hit
);

    logic [ADDR_W-1:0] keep_mask;
    logic              addr_eq;
    logic              kind_ok;

    // Build the mask of address bits that take part in the compare.
    always_comb begin
        keep_mask = ~{{(ADDR_W-LOW_BITS){1'b0}}, win_drop_bits(slot_ctl.win)};
    end

    // XOR-and-mask equality of the aligned addresses.
    always_comb begin
        addr_eq = ((acc_addr ^ slot_addr) & keep_mask) == '0;
    end

    // Decide whether this access kind is watched by the slot.
    always_comb begin
        case (slot_ctl.kind)
            KIND_MWR: kind_ok = acc_write && !acc_io;
            KIND_IO:  kind_ok = acc_io;
            KIND_MRW: kind_ok = !acc_io;
            default:  kind_ok = 1'b0;
        endcase
    end

    // Combine enable, kind filter and address equality.
    always_comb begin
        hit = slot_ctl.en && kind_ok && addr_eq;
    end

endmodule

// File: rtl/wpt_hit_stage.sv
// Module wpt_hit_stage
// Registers the per-slot match vector and the combined break pulse.
// Assumes match is only meaningful when valid is high. Otherwise it is
// discarded.
module wpt_hit_stage #(
    parameter int NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid,
    input  logic [NUM_SLOTS-1:0] match,
    output logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 brk_pulse
);

    // Capture qualified matches one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_vec   <= '0;
            brk_pulse <= 1'b0;
        end else begin
            hit_vec   <= valid ? match : '0;
            brk_pulse <= valid && (|match);
        end
    end

endmodule

// File: rtl/wpt_unit.sv
// Module wpt_unit
// Top of the watchpoint comparator. It normalises each request address,
// compares it against every slot in parallel and registers the results.
// Slots are loaded through the cfg_* port.
// Assumes all inputs are synchronous to clk and cfg_slot names a real slot.
module wpt_unit
    import wpt_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    parameter int IO_W      = 16,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_is_write,
    input  logic                 req_is_io,
    input  logic                 cfg_wr_en,
    input  logic [IDX_W-1:0]     cfg_slot,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [1:0]           cfg_len,
    input  logic [1:0]           cfg_kind,
    input  logic                 cfg_enable,
    output logic [NUM_SLOTS-1:0] hit_vec,
    output logic                 brk_pulse
);

    slot_ctl_t                        wr_ctl;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    slot_ctl_t [NUM_SLOTS-1:0]        slot_ctl;
    logic [ADDR_W-1:0]                cmp_addr;
    logic [NUM_SLOTS-1:0]             match;

    // Pack the configuration fields into a slot control record.
    always_comb begin
        wr_ctl.en   = cfg_enable;
        wr_ctl.win  = win_e'(cfg_len);
        wr_ctl.kind = kind_e'(cfg_kind);
    end

    wpt_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .ADDR_W    (ADDR_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .wr_idx    (cfg_slot),
        .wr_addr   (cfg_addr),
        .wr_ctl    (wr_ctl),
        .slot_addr (slot_addr),
        .slot_ctl  (slot_ctl)
    );

    wpt_access_norm #(
        .ADDR_W (ADDR_W),
        .IO_W   (IO_W)
    ) u_norm (
        .addr     (req_addr),
        .is_io    (req_is_io),
        .cmp_addr (cmp_addr)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cmp
        wpt_slot_cmp #(
            .ADDR_W (ADDR_W)
        ) u_cmp (
            .acc_addr  (cmp_addr),
            .acc_write (req_is_write),
            .acc_io    (req_is_io),
            .slot_addr (slot_addr[s]),
            .slot_ctl  (slot_ctl[s]),
            .hit       (match[s])
        );
    end

    wpt_hit_stage #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_hit (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid     (req_valid),
        .match     (match),
        .hit_vec   (hit_vec),
        .brk_pulse (brk_pulse)
    );

endmodule

// File: rtl/wpt_unit_checker.sv
// Module wpt_unit_checker
// Temporal properties of wpt_unit, observed at its ports only.
// Assumes reset is asserted at the first clock edge.
module wpt_unit_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int ADDR_W    = 32,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 req_is_write,
    input logic                 req_is_io,
    input logic                 cfg_wr_en,
    input logic [IDX_W-1:0]     cfg_slot,
    input logic [ADDR_W-1:0]    cfg_addr,
    input logic [1:0]           cfg_len,
    input logic [1:0]           cfg_kind,
    input logic                 cfg_enable,
    input logic [NUM_SLOTS-1:0] hit_vec,
    input logic                 brk_pulse
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (hit_vec == '0) && !brk_pulse);

    assert_idle_no_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (hit_vec == '0) && !brk_pulse);

    assert_pulse_is_or_R11: assert property (@(posedge clk) disable iff (!rst_n)
        brk_pulse == (hit_vec != '0));

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot_chk
        assert_disabled_slot_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_slot == IDX_W'(k) && (!cfg_enable || cfg_kind == 2'b00))
            |=> ##1 !hit_vec[k]);

        assert_write_only_ignores_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_slot == IDX_W'(k) && cfg_kind == 2'b01)
            ##1 (req_valid && (!req_is_write || req_is_io))
            |=> !hit_vec[k]);

        assert_mem_kind_ignores_io_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_wr_en && cfg_slot == IDX_W'(k) && cfg_kind == 2'b11)
            ##1 (req_valid && req_is_io)
            |=> !hit_vec[k]);
    end

endmodule

bind wpt_unit wpt_unit_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W)
) u_chk (.*);

// File: tb/wpt_unit_bench.sv
// Scoreboard bench for wpt_unit: a driver task pushes the expected result
// of each cycle and a monitor pops and compares it after each rising edge.
module wpt_unit_bench;

    localparam int  NS       = 4;
    localparam time PERIOD   = 8ns;
    localparam int  WD_LIMIT = 200000;

    typedef struct {
        logic [NS-1:0] vec;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [31:0]   req_addr = '0;
    logic          req_is_write = 1'b0;
    logic          req_is_io = 1'b0;
    logic          cfg_wr_en = 1'b0;
    logic [1:0]    cfg_slot = '0;
    logic [31:0]   cfg_addr = '0;
    logic [1:0]    cfg_len = '0;
    logic [1:0]    cfg_kind = '0;
    logic          cfg_enable = 1'b0;
    logic [NS-1:0] hit_vec;
    logic          brk_pulse;

    int   n_checks = 0;
    int   n_fail   = 0;
    bit   done     = 1'b0;
    exp_t sb[$];

    // Model of slot contents written from the requirements.
    logic [31:0] m_addr [NS];
    logic [1:0]  m_len  [NS];
    logic [1:0]  m_kind [NS];
    logic        m_en   [NS];

    wpt_unit u_wpt_unit (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr),
        .req_is_write(req_is_write), .req_is_io(req_is_io),
        .cfg_wr_en(cfg_wr_en), .cfg_slot(cfg_slot), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_kind(cfg_kind), .cfg_enable(cfg_enable),
        .hit_vec(hit_vec), .brk_pulse(brk_pulse)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [NS-1:0] model(logic [31:0] a, logic w, logic io);
        logic [NS-1:0] r;
        logic [31:0]   ea;
        logic [31:0]   mk;
        logic          kok;
        r  = '0;
        ea = io ? {16'h0, a[15:0]} : a;
        for (int s = 0; s < NS; s++) begin
            case (m_len[s])
                2'b00:   mk = 32'hFFFF_FFFF;
                2'b01:   mk = 32'hFFFF_FFFE;
                2'b11:   mk = 32'hFFFF_FFFC;
                default: mk = 32'hFFFF_FFF8;
            endcase
            case (m_kind[s])
                2'b01:   kok = w && !io;
                2'b10:   kok = io;
                2'b11:   kok = !io;
                default: kok = 1'b0;
            endcase
            r[s] = m_en[s] && kok && (((ea ^ m_addr[s]) & mk) == 32'h0);
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [NS:0] act, logic [NS:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual {pulse,vec}=%b expected %b", tag, act, exp);
        end
    endtask

    // One driven cycle: optional slot write plus optional request.
    task automatic step(bit dc, logic [1:0] sl, logic [31:0] ca, logic [1:0] ln,
                        logic [1:0] kd, logic en, bit v, logic [31:0] a,
                        logic w, logic io, string tag);
        exp_t e;
        @(negedge clk);
        e.vec = v ? model(a, w, io) : '0;
        e.tag = tag;
        sb.push_back(e);
        if (dc) begin
            m_addr[sl] = ca; m_len[sl] = ln; m_kind[sl] = kd; m_en[sl] = en;
        end
        cfg_wr_en = dc; cfg_slot = sl; cfg_addr = ca; cfg_len = ln;
        cfg_kind = kd; cfg_enable = en;
        req_valid = v; req_addr = a; req_is_write = w; req_is_io = io;
    endtask

    task automatic cfg(logic [1:0] sl, logic [31:0] ca, logic [1:0] ln,
                       logic [1:0] kd, logic en);
        step(1, sl, ca, ln, kd, en, 0, '0, 0, 0, "R2_cfg_idle");
    endtask

    task automatic acc(logic [31:0] a, logic w, logic io, string tag);
        step(0, 0, '0, 0, 0, 0, 1, a, w, io, tag);
    endtask

    // Monitor: compare each registered result with the scoreboard head.
    initial begin
        forever begin
            @(posedge clk);
            #2ns;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({brk_pulse, hit_vec} == {|e.vec, e.vec}, e.tag,
                      {brk_pulse, hit_vec}, {|e.vec, e.vec});
            end
        end
    end

    initial begin
        for (int s = 0; s < NS; s++) begin
            m_addr[s] = '0; m_len[s] = '0; m_kind[s] = '0; m_en[s] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({brk_pulse, hit_vec} == '0, "R1_reset_outputs", {brk_pulse, hit_vec}, '0);
        acc(32'h0000_0000, 0, 0, "R1_all_disabled");
        acc(32'h0000_1000, 1, 0, "R1_all_disabled");

        cfg(0, 32'h0000_1000, 2'b00, 2'b11, 1);
        acc(32'h0000_1000, 0, 0, "R3_exact_hit");
        acc(32'h0000_1001, 0, 0, "R3_neighbour_miss");

        cfg(1, 32'h0000_2001, 2'b01, 2'b11, 1);
        acc(32'h0000_2000, 0, 0, "R4_low_hit");
        acc(32'h0000_2001, 1, 0, "R4_high_hit");
        acc(32'h0000_2002, 0, 0, "R4_outside_miss");

        cfg(2, 32'h0000_0F02, 2'b11, 2'b11, 1);
        acc(32'h0000_0F00, 0, 0, "R5_aligned_base_hit");
        acc(32'h0000_0F03, 1, 0, "R5_top_hit");
        acc(32'h0000_0F04, 1, 0, "R5_straddle_miss");

        cfg(3, 32'h0000_3008, 2'b10, 2'b11, 1);
        acc(32'h0000_300F, 0, 0, "R6_top_hit");
        acc(32'h0000_3010, 0, 0, "R6_above_miss");
        acc(32'h0000_3007, 0, 0, "R6_below_miss");

        cfg(0, 32'h0000_1000, 2'b00, 2'b01, 1);
        acc(32'h0000_1000, 1, 0, "R8_mem_write_hit");
        acc(32'h0000_1000, 0, 0, "R8_mem_read_miss");
        acc(32'h0000_1000, 1, 1, "R8_io_write_miss");

        cfg(1, 32'h0000_0040, 2'b00, 2'b10, 1);
        acc(32'hABCD_0040, 0, 1, "R9_io_read_zero_ext_hit");
        acc(32'h0000_0040, 1, 1, "R9_io_write_hit");
        acc(32'h0000_0040, 0, 0, "R9_mem_read_miss");

        acc(32'h0000_0F00, 0, 1, "R10_io_miss");
        acc(32'h0000_0F01, 1, 0, "R10_mem_write_hit");

        cfg(3, 32'h0000_3008, 2'b10, 2'b11, 0);
        acc(32'h0000_3008, 0, 0, "R7_disabled_miss");
        cfg(3, 32'h0000_3008, 2'b10, 2'b00, 1);
        acc(32'h0000_3008, 1, 0, "R7_kind_none_miss");

        cfg(0, 32'h0000_5000, 2'b11, 2'b11, 1);
        cfg(1, 32'h0000_5002, 2'b11, 2'b11, 1);
        acc(32'h0000_5001, 0, 0, "R11_two_slots_hit");

        step(1, 0, 32'h0000_5000, 2'b11, 2'b11, 0, 1, 32'h0000_5000, 0, 0,
             "R12_same_cycle_old_contents");
        acc(32'h0000_5000, 0, 0, "R12_next_cycle_new_contents");
        step(0, 0, '0, 0, 0, 0, 0, 32'h0000_5000, 0, 0, "R2_idle_no_hit");

        for (int i = 0; i < 300; i++) begin
            if (i % 10 == 0) begin
                cfg(2'($urandom_range(0, 3)), 32'h0000_8000 | 32'($urandom_range(0, 31)),
                    2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)));
            end
            acc(32'h0000_8000 | 32'($urandom_range(0, 31)) | ($urandom_range(0, 1) << 20),
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R11_mixed_sweep");
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule